// File: doc/BRIEF.md
# Hibernate and Wake-Source Controller

This block governs a module's low-power hibernate state. Software first enables one or more wake sources in an eight-bit control register. It then sets the hibernate-request bit. While the block is hibernating it watches the enabled wake inputs: a touch event, a wake line from the power-management chip, an interrupt pin of either polarity, and a reset request. When any enabled source becomes active, the block leaves hibernate and raises a one-cycle wake event.

The register is written through a single strobe. A companion address line picks the write mode. In set mode each one bit of the data sets the matching register bit. In clear mode each one bit clears it. The register value can always be read back. A hibernate request is refused when no wake source is enabled, so the block can never enter a state it is unable to leave. The four wake inputs are asynchronous and pass through two synchronizing flops before they are used.

Top module: `hib_wake_top`

## Requirements
- R1: After reset, rdData is 0x00, hibOut is low and wakeEvt is low.
- R2: A write with wrClr=0 ORs wrData into the register, and a write with wrClr=1 clears every register bit whose wrData bit is one. The new value appears on rdData after the writing clock edge. Bits 7 and 6 always read as zero.
- R3: Register bit map: bit 0 is the hibernate request, bit 1 enables touch wake, bit 2 enables power-management wake, bit 3 enables wake on irqIn high, bit 4 enables wake on reset request, and bit 5 enables wake on irqIn low.
- R4: A request to set bit 0 is accepted only if at least one of bits 5..1 is one after the same write. Otherwise bit 0 reads as zero and hibOut stays low.
- R5: hibOut equals register bit 0. It rises on the clock edge that accepts the request.
- R6: Each wake input passes two synchronizing flops. When an enabled source becomes active while the block is hibernating, hibOut falls on the third rising clock edge after the change.
- R7: Only enabled sources can wake the block. An active input whose enable bit is zero leaves hibOut high.
- R8: On a wake, bit 0 clears, bits 5..1 keep their values, and wakeEvt is high for the cycle in which hibOut first reads low.
- R9: Leaving hibernate by software does not raise wakeEvt and leaves the enables unchanged. Software can leave hibernate in two ways: a clear-mode write of bit 0, or a clear-mode write that removes every enable (which also forces bit 0 to zero).
- R10: wakeEvt is a single-cycle pulse, and it stays low even if the waking input remains active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| wrClr | input | 1 | Write mode: 0 set bits, 1 clear bits |
| wrData | input | 8 | Write data (bit mask) |
| touchIn | input | 1 | Touch wake input, active high, asynchronous |
| pmicWakeIn | input | 1 | Power-management wake input, active high, asynchronous |
| irqIn | input | 1 | Interrupt pin, either polarity can wake |
| rstReqIn | input | 1 | Reset-request wake input, active high, asynchronous |
| hibOut | output | 1 | High while hibernating (power-down request) |
| wakeEvt | output | 1 | One-cycle pulse when a wake source ends hibernate |
| rdData | output | 8 | Register readback |

## Verification
The assertions assume that a register write never lands in the same cycle as a wake. They also assume that each wake input stays steady long enough to cross the two synchronizing flops. The stimulus writes only while no enabled source is active. It holds each wake input for several cycles, and after releasing an input it waits for the synchronizer to drain before the next case. The irqIn pin idles low and is moved high before the low-polarity case, so enabling that source never fires at once by accident.

// File: rtl/hib_wake_pkg.sv
package hib_wake_pkg;
  localparam int REG_W      = 8;
  localparam int ENABLE_W   = 5;
  localparam int SRC_W      = 4;
  localparam int SYNC_DEPTH = 2;

  // register bit positions (software-visible encoding)
  localparam int BIT_ENTER    = 0;
  localparam int BIT_TOUCH    = 1;
  localparam int BIT_PMIC     = 2;
  localparam int BIT_IRQ_HIGH = 3;
  localparam int BIT_RST_REQ  = 4;
  localparam int BIT_IRQ_LOW  = 5;

  // raw source vector order
  localparam int SRC_TOUCH = 0;
  localparam int SRC_PMIC  = 1;
  localparam int SRC_IRQ   = 2;
  localparam int SRC_RST   = 3;

  typedef struct packed {
    logic updEn;
    logic clrMode;
  } ctrlStrobe_t;
endpackage

// File: rtl/hib_wake_sync.sv
module hib_wake_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hib_wake_dp.sv
module hib_wake_dp
  import hib_wake_pkg::*;
#(
  parameter int RW     = REG_W,
  parameter int EW     = ENABLE_W,
  parameter int SW     = SRC_W,
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [EW-1:0] wrMask,
  input  logic          hibState,
  input  logic [SW-1:0] srcRaw,
  output logic          enNextAny,
  output logic          wakeHit,
  output logic [RW-1:0] rdData
);
  localparam int PAD = RW - EW - 1;

  logic [EW-1:0] enReg;
  logic [EW-1:0] enNext;
  logic [SW-1:0] srcSync;
  logic [EW-1:0] srcActive;

  hib_wake_sync #(.WIDTH(SW), .STAGES(STAGES)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(srcRaw),
    .syncOut(srcSync)
  );

  // active-condition vector aligned with the enable bits 5..1
  always_comb begin
    srcActive = '0;
    srcActive[BIT_TOUCH-1]    = srcSync[SRC_TOUCH];
    srcActive[BIT_PMIC-1]     = srcSync[SRC_PMIC];
    srcActive[BIT_IRQ_HIGH-1] = srcSync[SRC_IRQ];
    srcActive[BIT_RST_REQ-1]  = srcSync[SRC_RST];
    srcActive[BIT_IRQ_LOW-1]  = ~srcSync[SRC_IRQ];
  end

  always_comb begin
    enNext = enReg;
    if (strobe.updEn) begin
      if (strobe.clrMode) enNext = enReg & ~wrMask;
      else                enNext = enReg | wrMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReg <= '0;
    else       enReg <= enNext;
  end

  assign enNextAny = |enNext;
  assign wakeHit   = |(enReg & srcActive);
  assign rdData    = {{PAD{1'b0}}, enReg, hibState};
endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl
  import hib_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrClr,
  input  logic        wrEnterBit,
  input  logic        enNextAny,
  input  logic        wakeHit,
  output ctrlStrobe_t strobe,
  output logic        hibState,
  output logic        wakeEvt
);
  typedef enum logic {ST_AWAKE = 1'b0, ST_HIB = 1'b1} hibSt_e;

  hibSt_e stateQ, stateD;
  logic   wakeNow;

  assign strobe.updEn   = wrEn;
  assign strobe.clrMode = wrClr;

  always_comb begin
    wakeNow = (stateQ == ST_HIB) && wakeHit;
    stateD  = wakeNow ? ST_AWAKE : stateQ;
    if (wrEn && wrEnterBit) stateD = wrClr ? ST_AWAKE : ST_HIB;
    if (!enNextAny)         stateD = ST_AWAKE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_AWAKE;
      wakeEvt <= 1'b0;
    end else begin
      stateQ  <= stateD;
      wakeEvt <= wakeNow;
    end
  end

  assign hibState = (stateQ == ST_HIB);
endmodule

// File: rtl/hib_wake_top.sv
module hib_wake_top
  import hib_wake_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrClr,
  input  logic [REG_W-1:0] wrData,
  input  logic             touchIn,
  input  logic             pmicWakeIn,
  input  logic             irqIn,
  input  logic             rstReqIn,
  output logic             hibOut,
  output logic             wakeEvt,
  output logic [REG_W-1:0] rdData
);
  ctrlStrobe_t      strobe;
  logic             enNextAny;
  logic             wakeHit;
  logic             hibState;
  logic [SRC_W-1:0] srcRaw;

  always_comb begin
    srcRaw            = '0;
    srcRaw[SRC_TOUCH] = touchIn;
    srcRaw[SRC_PMIC]  = pmicWakeIn;
    srcRaw[SRC_IRQ]   = irqIn;
    srcRaw[SRC_RST]   = rstReqIn;
  end

  hib_wake_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrClr     (wrClr),
    .wrEnterBit(wrData[BIT_ENTER]),
    .enNextAny (enNextAny),
    .wakeHit   (wakeHit),
    .strobe    (strobe),
    .hibState  (hibState),
    .wakeEvt   (wakeEvt)
  );

  hib_wake_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrMask   (wrData[BIT_IRQ_LOW:BIT_TOUCH]),
    .hibState (hibState),
    .srcRaw   (srcRaw),
    .enNextAny(enNextAny),
    .wakeHit  (wakeHit),
    .rdData   (rdData)
  );

  assign hibOut = hibState;
endmodule

// File: rtl/hib_wake_chk.sv
module hib_wake_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       wrClr,
  input logic [7:0] wrData,
  input logic       hibOut,
  input logic       wakeEvt,
  input logic [7:0] rdData
);
  p_wake_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |=> !wakeEvt);

  p_wake_exits_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvt |-> (!hibOut && $past(hibOut)));

  p_enables_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wakeEvt && !$past(wrEn)) |-> (rdData[5:1] == $past(rdData[5:1])));

  p_hib_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    hibOut |-> (rdData[5:1] != 5'd0));

  p_set_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrClr) |=> ((rdData[5:1] & $past(wrData[5:1])) == $past(wrData[5:1])));

  p_clr_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrClr) |=> ((rdData[5:1] & $past(wrData[5:1])) == 5'd0));
endmodule

bind hib_wake_top hib_wake_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrClr  (wrClr),
  .wrData (wrData),
  .hibOut (hibOut),
  .wakeEvt(wakeEvt),
  .rdData (rdData)
);

// File: tb/hib_wake_tb.sv
module hib_wake_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrClr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       touchIn = 1'b0;
  logic       pmicWakeIn = 1'b0;
  logic       irqIn = 1'b0;
  logic       rstReqIn = 1'b0;
  logic       hibOut;
  logic       wakeEvt;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hib_wake_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrClr(wrClr), .wrData(wrData),
    .touchIn(touchIn), .pmicWakeIn(pmicWakeIn), .irqIn(irqIn), .rstReqIn(rstReqIn),
    .hibOut(hibOut), .wakeEvt(wakeEvt), .rdData(rdData)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one register write; returns at the negedge after the writing edge
  task automatic regWrite(logic clr, logic [7:0] data);
    wrEn = 1'b1; wrClr = clr; wrData = data;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrClr = 1'b0; wrData = 8'h00;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every wake pulse must match an expected item
  always @(negedge clk) begin
    if (rstN && wakeEvt) begin
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R10: actual wakeEvt 1 expected 0 (no wake pending) at %0t", $time);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        chk("R8 readback at wake", rdData, e);
        chk("R8 hibOut low at wake", {7'd0, hibOut}, 8'h00);
      end
    end
  end

  // enable mask, hibernate, fire one source, check the three-edge latency
  task automatic wakeCase(string req, logic [7:0] enMask, int src);
    regWrite(1'b0, enMask);
    regWrite(1'b0, 8'h01);
    chk({req, " R5 entered"}, {7'd0, hibOut}, 8'h01);
    expQ.push_back(enMask);
    case (src)
      0: touchIn = 1'b1;
      1: pmicWakeIn = 1'b1;
      2: irqIn = 1'b1;
      3: rstReqIn = 1'b1;
      default: irqIn = 1'b0;
    endcase
    idle(2);
    chk({req, " R6 still asleep after two edges"}, {7'd0, hibOut}, 8'h01);
    idle(1);
    chk({req, " R6 awake on third edge"}, {7'd0, hibOut}, 8'h00);
    chk({req, " R8 wake pulse"}, {7'd0, wakeEvt}, 8'h01);
    idle(1);
    chk({req, " R10 pulse ends while input held"}, {7'd0, wakeEvt}, 8'h00);
    chk({req, " R8 enables kept"}, rdData, enMask);
    touchIn = 1'b0; pmicWakeIn = 1'b0; rstReqIn = 1'b0;
    regWrite(1'b1, 8'hFF);
    idle(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 hibOut", {7'd0, hibOut}, 8'h00);
    chk("R1 wakeEvt", {7'd0, wakeEvt}, 8'h00);

    // R4: request with no enable is refused
    regWrite(1'b0, 8'h01);
    chk("R4 refused readback", rdData, 8'h00);
    chk("R4 refused hibOut", {7'd0, hibOut}, 8'h00);

    // R2/R3: set and clear modes, upper bits read zero
    regWrite(1'b0, 8'hC2);
    chk("R2 set touch, upper bits zero", rdData, 8'h02);
    regWrite(1'b0, 8'h30);
    chk("R3 set reset and irq-low enables", rdData, 8'h32);
    regWrite(1'b1, 8'h12);
    chk("R2 clear selected bits", rdData, 8'h20);
    regWrite(1'b1, 8'hFF);
    chk("R2 clear all", rdData, 8'h00);

    // R4/R5: accepted request in the same write as an enable
    regWrite(1'b0, 8'h03);
    chk("R4 accepted readback", rdData, 8'h03);
    chk("R5 hibOut follows bit 0", {7'd0, hibOut}, 8'h01);

    // R7: disabled sources do not wake
    pmicWakeIn = 1'b1; irqIn = 1'b1; rstReqIn = 1'b1;
    idle(6);
    chk("R7 disabled sources ignored", {7'd0, hibOut}, 8'h01);
    pmicWakeIn = 1'b0; irqIn = 1'b0; rstReqIn = 1'b0;
    idle(4);
    chk("R7 still hibernating", rdData, 8'h03);

    // R9: software exit by clearing bit 0
    regWrite(1'b1, 8'h01);
    chk("R9 clear bit0 exits", {7'd0, hibOut}, 8'h00);
    chk("R9 no wake pulse", {7'd0, wakeEvt}, 8'h00);
    chk("R9 enables kept", rdData, 8'h02);

    // R9: removing every enable exits
    regWrite(1'b0, 8'h01);
    chk("R9 re-entered", {7'd0, hibOut}, 8'h01);
    regWrite(1'b1, 8'h02);
    chk("R9 all enables removed", rdData, 8'h00);
    chk("R9 no wake pulse on enable removal", {7'd0, wakeEvt}, 8'h00);
    idle(2);

    // R6/R8 per source and polarity
    wakeCase("touch", 8'h02, 0);
    wakeCase("pmic", 8'h04, 1);
    wakeCase("irq high", 8'h08, 2);
    irqIn = 1'b0;
    idle(4);
    wakeCase("reset request", 8'h10, 3);
    irqIn = 1'b1;
    idle(4);
    wakeCase("irq low", 8'h20, 4);
    idle(4);

    nChecks++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL R8: actual %0d pending wakes expected 0", expQ.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule